// File: doc/BRIEF.md
# Data-Cache Store Buffer with Drain Arbitration

This block sits between a processor pipeline and the data array of a write-back data cache. A store whose tag check has hit never touches the data array itself. It is parked in a small queue as a doubleword index, a byte-enable mask and 64 bits of data. Stores of any width (byte, halfword, word or doubleword) use this same path. Parked entries are written into the array later, one per cycle, oldest first, in any cycle where no load is reading the array. Because the write is byte-masked, a narrow store never needs a read-modify-write of the 64-bit array word.

Loads always win the single array port. A load whose doubleword index equals that of a parked entry raises `stall`. The pipeline holds the load, and the queue drains until no parked entry matches; the load then reads the updated array. A flush request also holds `stall` high until the queue is empty. The data array is modelled inside the block as a single-port memory with a registered read. Its write side is brought out on ports so that the drain traffic can be observed.

Top module: `dcache_store_buffer`

## Requirements
- R1: During and after reset the queue is empty, `stall`, `arr_we` and `ld_done` are low, and every array doubleword reads as zero.
- R2: A store presented with `st_valid` high and `st_hit` low raises `st_miss` in the same cycle and leaves the queue and the array unchanged; a store with `st_hit` high is taken into the queue in any cycle where `stall` is low.
- R3: In a cycle where a load is served (`ld_valid` high and `stall` low), `arr_we` is low.
- R4: In each cycle without a served load, the oldest parked entry, and only that one, is written to the array (`arr_we` high with its index, mask and data). Entries leave in arrival order and the queue never holds more than DEPTH entries.
- R5: A drain writes only the bytes whose mask bit is set (mask bit b covers data bits 8b+7..8b); the other bytes of that array doubleword keep their value.
- R6: A load whose index equals that of any parked entry raises `stall`. It stays stalled until no parked entry matches. Since draining is oldest first, the stall lasts as many cycles as the position of the youngest matching entry counted from one. The load then returns the doubleword with all earlier stores applied.
- R7: An unbroken run of loads, an unbroken run of stores, or stores followed by loads to other doublewords complete with no stall cycles; any entries left over stay parked.
- R8: When the queue is full and a hit store arrives in a cycle with no load, the oldest entry drains and the store is taken in that same cycle without a stall.
- R9: When the queue is full and a hit store arrives together with a load that would be served, `stall` is raised for one cycle. In that cycle the oldest entry drains and neither operation proceeds; both proceed in the next cycle.
- R10: While `flush` is high and the queue is not empty, `stall` is high; with an empty queue `flush` raises no stall.
- R11: A load served in cycle t gives `ld_done` high and the array doubleword in `ld_rdata` in cycle t+1.
- R12: A store taken into the queue in the same cycle as a served load to the same index is treated as younger than the load: the load returns the value from before that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | A store has finished its tag check this cycle |
| st_hit | input | 1 | Tag check result for the store (1 = hit) |
| st_idx | input | IDX_W | Doubleword index of the store |
| st_mask | input | 8 | Byte enables of the store |
| st_data | input | 64 | Store data, byte lanes aligned to the doubleword |
| st_miss | output | 1 | Store rejected by the tag check, nothing enqueued |
| ld_valid | input | 1 | A load needs the data array this cycle |
| ld_idx | input | IDX_W | Doubleword index of the load |
| ld_rdata | output | 64 | Load result, one cycle after the load is served |
| ld_done | output | 1 | `ld_rdata` is valid |
| flush | input | 1 | Request to empty the queue |
| stall | output | 1 | Pipeline must hold its current load and store |
| arr_we | output | 1 | Drain write to the data array this cycle |
| arr_idx | output | IDX_W | Index of the drain write |
| arr_mask | output | 8 | Byte enables of the drain write |
| arr_wdata | output | 64 | Data of the drain write |

## Verification
Two functions of this block meet in one cycle: a load claiming the array port and a drain of the oldest entry. The second pair is a store entering a full queue while that same drain frees a slot. The bench sets these up by filling the queue with stores issued alongside loads. It then offers a store alone, a store together with a load, and a load to a parked index. A bench-side model of the queue predicts, for each cycle, whether `stall` and `arr_we` rise and which entry is written. The bench compares the returned load data with a byte-exact memory updated in program order, and checks the stall count of each scenario.

// File: rtl/dcsb_pkg.sv
package dcsb_pkg;
  localparam int unsigned DW = 64;
  localparam int unsigned BW = DW / 8;

  typedef logic [DW-1:0] dword_t;
  typedef logic [BW-1:0] bmask_t;

  // Overlay the enabled byte lanes of new_w onto old_w.
  function automatic dword_t merge_bytes(dword_t old_w, dword_t new_w, bmask_t m);
    dword_t r;
    r = old_w;
    for (int b = 0; b < int'(BW); b++) begin
      if (m[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/dcsb_queue.sv
module dcsb_queue
  import dcsb_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [IDX_W-1:0]           push_idx,
  input  bmask_t                     push_mask,
  input  dword_t                     push_data,
  input  logic                       pop,
  output logic [IDX_W-1:0]           head_idx,
  output bmask_t                     head_mask,
  output dword_t                     head_data,
  output logic [DEPTH-1:0]           vld_vec,
  output logic [DEPTH-1:0][IDX_W-1:0] idx_vec,
  output logic [CNT_W-1:0]           count
);
  // Slot 0 holds the oldest entry; a pop shifts every slot down by one.
  logic [IDX_W-1:0] q_idx  [DEPTH];
  bmask_t           q_mask [DEPTH];
  dword_t           q_data [DEPTH];
  logic             q_vld  [DEPTH];

  logic [IDX_W-1:0] n_idx  [DEPTH];
  bmask_t           n_mask [DEPTH];
  dword_t           n_data [DEPTH];
  logic             n_vld  [DEPTH];
  logic [CNT_W-1:0] wr_slot;

  always_comb begin
    count = '0;
    for (int k = 0; k < DEPTH; k++) count = count + CNT_W'(q_vld[k]);
  end

  assign wr_slot = pop ? (count - CNT_W'(1)) : count;

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      if (pop) begin
        if (k < DEPTH - 1) begin
          n_idx[k]  = q_idx[k+1];
          n_mask[k] = q_mask[k+1];
          n_data[k] = q_data[k+1];
          n_vld[k]  = q_vld[k+1];
        end else begin
          n_idx[k]  = q_idx[k];
          n_mask[k] = q_mask[k];
          n_data[k] = q_data[k];
          n_vld[k]  = 1'b0;
        end
      end else begin
        n_idx[k]  = q_idx[k];
        n_mask[k] = q_mask[k];
        n_data[k] = q_data[k];
        n_vld[k]  = q_vld[k];
      end
      if (push && (wr_slot == CNT_W'(k))) begin
        n_idx[k]  = push_idx;
        n_mask[k] = push_mask;
        n_data[k] = push_data;
        n_vld[k]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) begin
      if (!rst_n) begin
        q_idx[k]  <= '0;
        q_mask[k] <= '0;
        q_data[k] <= '0;
        q_vld[k]  <= 1'b0;
      end else begin
        q_idx[k]  <= n_idx[k];
        q_mask[k] <= n_mask[k];
        q_data[k] <= n_data[k];
        q_vld[k]  <= n_vld[k];
      end
    end
  end

  assign head_idx  = q_idx[0];
  assign head_mask = q_mask[0];
  assign head_data = q_data[0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign vld_vec[g] = q_vld[g];
    assign idx_vec[g] = q_idx[g];
  end
endmodule

// File: rtl/dcsb_match.sv
module dcsb_match #(
  parameter int IDX_W = 4,
  parameter int DEPTH = 2
) (
  input  logic                        probe_en,
  input  logic [IDX_W-1:0]            probe_idx,
  input  logic [DEPTH-1:0]            vld_vec,
  input  logic [DEPTH-1:0][IDX_W-1:0] idx_vec,
  output logic [DEPTH-1:0]            hit_vec,
  output logic                        hit_any
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = probe_en && vld_vec[g] && (idx_vec[g] == probe_idx);
  end
  assign hit_any = |hit_vec;
endmodule

// File: rtl/dcsb_array.sv
module dcsb_array
  import dcsb_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int ROWS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  bmask_t           wmask,
  input  dword_t           wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] ridx,
  output dword_t           rdata,
  output logic             rvalid
);
  dword_t mem [ROWS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) rdata <= mem[ridx];
      if (we) mem[widx] <= merge_bytes(mem[widx], wdata, wmask);
    end
  end
endmodule

// File: rtl/dcache_store_buffer.sv
module dcache_store_buffer
  import dcsb_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  input  logic             st_hit,
  input  logic [IDX_W-1:0] st_idx,
  input  logic [7:0]       st_mask,
  input  logic [63:0]      st_data,
  output logic             st_miss,
  input  logic             ld_valid,
  input  logic [IDX_W-1:0] ld_idx,
  output logic [63:0]      ld_rdata,
  output logic             ld_done,
  input  logic             flush,
  output logic             stall,
  output logic             arr_we,
  output logic [IDX_W-1:0] arr_idx,
  output logic [7:0]       arr_mask,
  output logic [63:0]      arr_wdata
);
  // Named internal events, also observed by the bound checker.
  logic                        push_w, pop_w, hazard_w, full_w;
  logic                        flush_stall_w, full_stall_w, ld_want_w, ld_served_w;
  logic [CNT_W-1:0]            count_w;
  logic [DEPTH-1:0]            vld_vec_w, hit_vec_w;
  logic [DEPTH-1:0][IDX_W-1:0] idx_vec_w;
  logic [IDX_W-1:0]            head_idx_w;
  bmask_t                      head_mask_w;
  dword_t                      head_data_w;

  dcsb_match #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_match (
    .probe_en (ld_valid),
    .probe_idx(ld_idx),
    .vld_vec  (vld_vec_w),
    .idx_vec  (idx_vec_w),
    .hit_vec  (hit_vec_w),
    .hit_any  (hazard_w)
  );

  assign full_w        = (count_w == CNT_W'(DEPTH));
  assign ld_want_w     = ld_valid && !hazard_w;
  assign flush_stall_w = flush && (count_w != '0);
  assign full_stall_w  = st_valid && st_hit && full_w && ld_want_w;
  assign stall         = hazard_w || flush_stall_w || full_stall_w;
  assign ld_served_w   = ld_valid && !stall;
  assign pop_w         = (count_w != '0) && !ld_served_w;
  assign push_w        = st_valid && st_hit && !stall;
  assign st_miss       = st_valid && !st_hit;

  dcsb_queue #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_w),
    .push_idx (st_idx),
    .push_mask(st_mask),
    .push_data(st_data),
    .pop      (pop_w),
    .head_idx (head_idx_w),
    .head_mask(head_mask_w),
    .head_data(head_data_w),
    .vld_vec  (vld_vec_w),
    .idx_vec  (idx_vec_w),
    .count    (count_w)
  );

  assign arr_we    = pop_w;
  assign arr_idx   = head_idx_w;
  assign arr_mask  = head_mask_w;
  assign arr_wdata = head_data_w;

  dcsb_array #(.IDX_W(IDX_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pop_w),
    .widx  (head_idx_w),
    .wmask (head_mask_w),
    .wdata (head_data_w),
    .re    (ld_served_w),
    .ridx  (ld_idx),
    .rdata (ld_rdata),
    .rvalid(ld_done)
  );
endmodule

// File: rtl/dcsb_checker.sv
module dcsb_checker #(
  parameter int DEPTH = 2,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_valid,
  input logic             stall,
  input logic             arr_we,
  input logic             st_miss,
  input logic             flush,
  input logic             ld_done,
  input logic             push_w,
  input logic             pop_w,
  input logic             hazard_w,
  input logic             full_w,
  input logic [CNT_W-1:0] count_w
);
  // R3
  load_owns_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !stall) |-> !arr_we);

  // R2
  miss_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_miss |-> !push_w);

  // R6
  hazard_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hazard_w |-> stall);

  // R10
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && count_w != '0) |-> stall);

  // R11
  load_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !stall) |=> ld_done);

  // R8
  full_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_w && push_w) |-> arr_we);

  // R4
  drain_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (count_w != '0));

  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_w <= CNT_W'(DEPTH));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> count_w == CNT_W'($past(count_w) + CNT_W'($past(push_w)) - CNT_W'($past(pop_w))));
endmodule

bind dcache_store_buffer dcsb_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ld_valid(ld_valid),
  .stall   (stall),
  .arr_we  (arr_we),
  .st_miss (st_miss),
  .flush   (flush),
  .ld_done (ld_done),
  .push_w  (push_w),
  .pop_w   (pop_w),
  .hazard_w(hazard_w),
  .full_w  (full_w),
  .count_w (count_w)
);

// File: tb/dcache_store_buffer_bench.sv
module dcache_store_buffer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0, st_hit = 1'b0;
  logic [3:0]  st_idx = '0;
  logic [7:0]  st_mask = '0;
  logic [63:0] st_data = '0;
  logic        st_miss;
  logic        ld_valid = 1'b0;
  logic [3:0]  ld_idx = '0;
  logic [63:0] ld_rdata;
  logic        ld_done;
  logic        flush = 1'b0;
  logic        stall;
  logic        arr_we;
  logic [3:0]  arr_idx;
  logic [7:0]  arr_mask;
  logic [63:0] arr_wdata;

  always #4 clk = ~clk;

  dcache_store_buffer u_dcache_store_buffer (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_hit(st_hit), .st_idx(st_idx), .st_mask(st_mask),
    .st_data(st_data), .st_miss(st_miss),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_rdata(ld_rdata), .ld_done(ld_done),
    .flush(flush), .stall(stall),
    .arr_we(arr_we), .arr_idx(arr_idx), .arr_mask(arr_mask), .arr_wdata(arr_wdata)
  );

  int checks = 0, failures = 0, last_stalls = 0;
  logic [63:0] ref_mem [16];
  int          m_cnt = 0;
  logic [3:0]  m_idx  [2];
  logic [7:0]  m_mask [2];
  logic [63:0] m_data [2];
  bit          pend_done = 0;
  logic [63:0] pend_data = '0;
  logic [31:0] lfsr = 32'h1badcafe;

  function automatic void chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic logic [63:0] lane_apply(logic [63:0] o, logic [63:0] n, logic [7:0] m);
    logic [63:0] sel;
    for (int b = 0; b < 8; b++) sel[b*8 +: 8] = {8{m[b]}};
    return (o & ~sel) | (n & sel);
  endfunction

  function automatic logic [31:0] next_rand(logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  task automatic op(input bit lv, input logic [3:0] li, input bit sv, input bit sh,
                    input logic [3:0] si, input logic [7:0] sm, input logic [63:0] sd,
                    input bit fl, input string tag);
    bit fin = 0;
    int guard = 0;
    last_stalls = 0;
    while (!fin) begin
      bit hz, pst, srv, drn, psh;
      ld_valid = lv; ld_idx = li; st_valid = sv; st_hit = sh;
      st_idx = si; st_mask = sm; st_data = sd; flush = fl;
      @(negedge clk);
      // R11: reply to the load served one cycle earlier
      chk(ld_done === pend_done, "R11 ld_done", 64'(ld_done), 64'(pend_done));
      if (pend_done) chk(ld_rdata === pend_data, "R6 load data", ld_rdata, pend_data);
      hz = 0;
      for (int k = 0; k < m_cnt; k++) if (lv && m_idx[k] == li) hz = 1;
      pst = hz || (fl && m_cnt != 0) || (sv && sh && m_cnt == 2 && lv && !hz);
      srv = lv && !pst;
      drn = (m_cnt != 0) && !srv;
      psh = sv && sh && !pst;
      chk(stall === pst, {tag, " stall"}, 64'(stall), 64'(pst));
      chk(arr_we === drn, "R3 arr_we", 64'(arr_we), 64'(drn));
      if (drn && arr_we) begin
        chk(arr_idx === m_idx[0], "R4 drain index", 64'(arr_idx), 64'(m_idx[0]));
        chk(arr_mask === m_mask[0], "R5 drain mask", 64'(arr_mask), 64'(m_mask[0]));
        chk(arr_wdata === m_data[0], "R4 drain data", arr_wdata, m_data[0]);
      end
      chk(st_miss === (sv && !sh), "R2 st_miss", 64'(st_miss), 64'(sv && !sh));
      pend_done = srv;
      pend_data = ref_mem[li];
      @(posedge clk);
      #1;
      if (drn) begin
        m_idx[0] = m_idx[1]; m_mask[0] = m_mask[1]; m_data[0] = m_data[1];
        m_cnt--;
      end
      if (psh) begin
        m_idx[m_cnt] = si; m_mask[m_cnt] = sm; m_data[m_cnt] = sd;
        m_cnt++;
        ref_mem[si] = lane_apply(ref_mem[si], sd, sm);
      end
      if (pst) last_stalls++;
      else fin = 1;
      guard++;
      if (guard > 20) begin
        chk(0, {tag, " stall never ended"}, 64'(guard), 64'(0));
        fin = 1;
      end
    end
    ld_valid = 0; st_valid = 0; st_hit = 0; flush = 0;
  endtask

  task automatic ld(input logic [3:0] i, input string tag);
    op(1, i, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic st(input logic [3:0] i, input logic [7:0] m, input logic [63:0] d, input string tag);
    op(0, 0, 1, 1, i, m, d, 0, tag);
  endtask
  task automatic drain_all(input string tag);
    op(0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask
  // Park two entries (indices a and b) using loads to far indices so nothing drains.
  task automatic fill2(input logic [3:0] a, input logic [3:0] b);
    drain_all("R10 prep");
    op(1, 4'd15, 1, 1, a, 8'hff, {16'h0a0a, 44'd0, a}, 0, "R7 fill");
    op(1, 4'd14, 1, 1, b, 8'h0f, {16'h0b0b, 44'd0, b}, 0, "R7 fill");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = '0;
    for (int k = 0; k < 2; k++) begin m_idx[k] = '0; m_mask[k] = '0; m_data[k] = '0; end
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet during reset
    chk(stall === 1'b0, "R1 stall in reset", 64'(stall), 64'(0));
    chk(arr_we === 1'b0, "R1 arr_we in reset", 64'(arr_we), 64'(0));
    chk(ld_done === 1'b0, "R1 ld_done in reset", 64'(ld_done), 64'(0));
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R1 / R7: a run of loads over the whole array reads zero with no stall
    begin
      int tot = 0;
      for (int i = 0; i < 16; i++) begin ld(4'(i), "R1 load"); tot += last_stalls; end
      op(0, 0, 0, 0, 0, 0, 0, 0, "R11 idle");
      chk(tot == 0, "R7 load run stalls", 64'(tot), 64'(0));
    end

    // R7: a run of stores, then loads to other doublewords
    begin
      int tot = 0;
      for (int i = 0; i < 6; i++) begin st(4'(i), 8'h01 << i, 64'h1111_0000_0000_0000 * 64'(i + 1), "R7 store run"); tot += last_stalls; end
      for (int i = 8; i < 12; i++) begin ld(4'(i), "R7 load run"); tot += last_stalls; end
      chk(tot == 0, "R7 stores then loads stalls", 64'(tot), 64'(0));
    end

    // R6: hazard on the younger entry waits for both drains
    fill2(4'd1, 4'd2);
    ld(4'd2, "R6 hazard young");
    chk(last_stalls == 2, "R6 stalls young match", 64'(last_stalls), 64'(2));
    // R6: hazard on the oldest entry waits one drain
    fill2(4'd3, 4'd4);
    ld(4'd3, "R6 hazard old");
    chk(last_stalls == 1, "R6 stalls old match", 64'(last_stalls), 64'(1));

    // R8: full queue, store alone, accepted with same-cycle drain
    fill2(4'd5, 4'd6);
    st(4'd7, 8'hf0, 64'hdead_beef_0123_4567, "R8 full store");
    chk(last_stalls == 0, "R8 full store stalls", 64'(last_stalls), 64'(0));

    // R9: full queue, store plus load, one stall cycle
    fill2(4'd8, 4'd9);
    op(1, 4'd12, 1, 1, 4'd10, 8'h3c, 64'h5555_aaaa_5555_aaaa, 0, "R9 full store+load");
    chk(last_stalls == 1, "R9 collision stalls", 64'(last_stalls), 64'(1));

    // R10: flush with two entries stalls twice, with none not at all
    fill2(4'd11, 4'd12);
    drain_all("R10 flush");
    chk(last_stalls == 2, "R10 flush two entries", 64'(last_stalls), 64'(2));
    drain_all("R10 flush empty");
    chk(last_stalls == 0, "R10 flush empty", 64'(last_stalls), 64'(0));

    // R12: store and load to the same index in one cycle; load sees old data
    op(1, 4'd13, 1, 1, 4'd13, 8'hff, 64'hfeed_face_cafe_f00d, 0, "R12 same cycle");
    chk(last_stalls == 0, "R12 same cycle stalls", 64'(last_stalls), 64'(0));
    ld(4'd13, "R12 later load");

    // R2: a missed store enqueues nothing
    drain_all("R2 prep");
    op(0, 0, 1, 0, 4'd0, 8'hff, 64'hffff_ffff_ffff_ffff, 0, "R2 miss");
    drain_all("R2 flush after miss");
    chk(last_stalls == 0, "R2 miss left queue empty", 64'(last_stalls), 64'(0));
    ld(4'd0, "R2 miss load");

    // R5: exhaustive sweep of byte masks
    for (int m = 0; m < 256; m++) begin
      lfsr = next_rand(lfsr);
      op(1, 4'((m + 8) % 16), 1, 1, 4'(m % 16), 8'(m), {lfsr, ~lfsr}, 0, "R5 mask sweep");
    end
    drain_all("R5 sweep flush");
    for (int i = 0; i < 16; i++) ld(4'(i), "R5 sweep readback");

    // Mixed traffic on a narrow index range to force frequent hazards
    for (int n = 0; n < 1500; n++) begin
      lfsr = next_rand(lfsr);
      op(lfsr[8], {2'b00, lfsr[1:0]}, lfsr[9], lfsr[7:4] != 0, {2'b00, lfsr[3:2]},
         lfsr[23:16], {lfsr, next_rand(lfsr)}, lfsr[15:12] == 0, "R6 mixed");
    end
    drain_all("R10 final flush");
    for (int i = 0; i < 16; i++) ld(4'(i), "R4 final readback");
    op(0, 0, 0, 0, 0, 0, 0, 0, "R11 idle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule